// File: doc/BRIEF.md
# Program Counter Sequencer

This block holds the address of the next instruction word that a processor core fetches, and moves that address on as execution proceeds. It does not start from a wired-in constant. Coming out of reset, it first reads a start address from one fixed slot of a small vector-table memory, using a request/acknowledge read port. Only after that read completes does it mark its output valid.

Once running, the address changes in one of four ways. It steps forward by one when the core reports that an instruction has completed. It loads a supplied target on an absolute branch. It adds a sign-extended offset on a relative branch, which allows jumps both forward and backward. Otherwise it holds. All arithmetic wraps within the address width.

The core reads the registered address and the valid flag. It uses the address only when it is ready for its next fetch.

Top module: `pcseq_top`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `pc_vld` is 0, `pc` is 0, `vec_req` is 1 and `vec_addr` equals the parameter `VEC_SLOT` (default 2).
- R2: In a cycle where `vec_req` and `vec_ack` are both 1, the next cycle has `pc` equal to the `vec_data` sampled in that cycle, `pc_vld` equal to 1 and `vec_req` equal to 0.
- R3: While the vector read is pending (`vec_req` high, `vec_ack` low), `done`, `br_req`, `br_rel` and `br_arg` are ignored: `pc` stays 0 and `pc_vld` stays 0.
- R4: When valid, `done` high with `br_req` low makes the next `pc` equal to `pc + 1` modulo 2^PC_W.
- R5: When valid, `br_req` high with `br_rel` low (absolute) makes the next `pc` equal to `br_arg`.
- R6: When valid, `br_req` high with `br_rel` high (relative) makes the next `pc` equal to `pc` plus `br_arg[OFS_W-1:0]` sign-extended, modulo 2^PC_W. The bits of `br_arg` above the offset field are ignored (default OFS_W = 8).
- R7: A branch request and `done` in the same cycle produce the branch result. The step does not happen.
- R8: When valid, with both `done` and `br_req` low, `pc` keeps its value.
- R9: After the vector read completes, `vec_req` stays 0 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| done | input | 1 | Current instruction has completed |
| br_req | input | 1 | Branch request |
| br_rel | input | 1 | 1 = relative branch, 0 = absolute branch |
| br_arg | input | PC_W | Absolute target, or offset in the low OFS_W bits |
| vec_req | output | 1 | Vector-table read request |
| vec_addr | output | VA_W | Vector-table slot address |
| vec_ack | input | 1 | Read data is valid this cycle |
| vec_data | input | PC_W | Start address read from the table |
| pc | output | PC_W | Next fetch address |
| pc_vld | output | 1 | The address is valid |

## Verification
The bench stalls the vector read for several cycles while driving completions and branches. A design that acted on them early would show a nonzero address, or a valid flag raised before the acknowledge.

It aims relative branches at the wrap points with the most negative offset, drives steps from the all-ones address, and puts junk in the upper bits of the offset. A design that zero-extends the offset, or that fails to mask those upper bits, lands on the wrong address.

It also raises a branch and a completion together. A design with the priority reversed would show `pc + 1` instead of the target.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int PC_W_DEF  = 16;
    localparam int OFS_W_DEF = 8;
    localparam int VA_W_DEF  = 4;

    typedef enum logic {
        ST_FETCH = 1'b0,
        ST_RUN   = 1'b1
    } boot_st_e;

    typedef enum logic [1:0] {
        SEL_HOLD = 2'd0,
        SEL_STEP = 2'd1,
        SEL_ABS  = 2'd2,
        SEL_REL  = 2'd3
    } nsel_e;

    typedef struct packed {
        logic done;
        logic br;
        logic rel;
    } ctl_t;

    // Branch outranks a plain completion.
    function automatic nsel_e pick_sel(ctl_t c);
        if (c.br)   return c.rel ? SEL_REL : SEL_ABS;
        if (c.done) return SEL_STEP;
        return SEL_HOLD;
    endfunction

endpackage

// File: rtl/pcseq_boot.sv
module pcseq_boot
    import pcseq_pkg::*;
#(
    parameter int VA_W     = VA_W_DEF,
    parameter int VEC_SLOT = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            vec_ack,
    output logic            vec_req,
    output logic [VA_W-1:0] vec_addr,
    output logic            load_vec,
    output logic            running
);

    boot_st_e st_q;

    always_ff @(posedge clk) begin
        if (rst)           st_q <= ST_FETCH;
        else if (load_vec) st_q <= ST_RUN;
    end

    always_comb begin
        vec_req  = (st_q == ST_FETCH);
        vec_addr = VA_W'(VEC_SLOT);
        load_vec = vec_req && vec_ack;
        running  = (st_q == ST_RUN);
    end

    // Once running, no further table read until reset.
    assert_single_fetch_R9: assert property (@(posedge clk) disable iff (rst)
        running |=> running && !vec_req);

endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
    import pcseq_pkg::*;
#(
    parameter int PC_W  = PC_W_DEF,
    parameter int OFS_W = OFS_W_DEF
) (
    input  logic [PC_W-1:0] pc_i,
    input  nsel_e           sel,
    input  logic [PC_W-1:0] arg_i,
    output logic [PC_W-1:0] nxt
);

    localparam int EXT_W = PC_W - OFS_W;
    localparam logic [PC_W-1:0] ONE = PC_W'(1);

    logic [PC_W-1:0] ofs_x;

    generate
        if (OFS_W < PC_W) begin : g_ext
            assign ofs_x = {{EXT_W{arg_i[OFS_W-1]}}, arg_i[OFS_W-1:0]};
        end else begin : g_full
            assign ofs_x = arg_i;
        end
    endgenerate

    always_comb begin
        case (sel)
            SEL_STEP: nxt = pc_i + ONE;
            SEL_ABS:  nxt = arg_i;
            SEL_REL:  nxt = pc_i + ofs_x;
            default:  nxt = pc_i;
        endcase
    end

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
    import pcseq_pkg::*;
#(
    parameter int PC_W     = PC_W_DEF,
    parameter int OFS_W    = OFS_W_DEF,
    parameter int VA_W     = VA_W_DEF,
    parameter int VEC_SLOT = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            done,
    input  logic            br_req,
    input  logic            br_rel,
    input  logic [PC_W-1:0] br_arg,
    output logic            vec_req,
    output logic [VA_W-1:0] vec_addr,
    input  logic            vec_ack,
    input  logic [PC_W-1:0] vec_data,
    output logic [PC_W-1:0] pc,
    output logic            pc_vld
);

    logic            load_vec;
    logic            running;
    ctl_t            ctl;
    nsel_e           sel;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_nxt;

    pcseq_boot #(.VA_W(VA_W), .VEC_SLOT(VEC_SLOT)) u_boot (
        .clk      (clk),
        .rst      (rst),
        .vec_ack  (vec_ack),
        .vec_req  (vec_req),
        .vec_addr (vec_addr),
        .load_vec (load_vec),
        .running  (running)
    );

    always_comb begin
        ctl = '{done: done, br: br_req, rel: br_rel};
        sel = running ? pick_sel(ctl) : SEL_HOLD;
    end

    pcseq_next #(.PC_W(PC_W), .OFS_W(OFS_W)) u_next (
        .pc_i  (pc_q),
        .sel   (sel),
        .arg_i (br_arg),
        .nxt   (pc_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)           pc_q <= '0;
        else if (load_vec) pc_q <= vec_data;
        else               pc_q <= pc_nxt;
    end

    assign pc     = pc_q;
    assign pc_vld = running;

    assert_boot_load_R2: assert property (@(posedge clk) disable iff (rst)
        vec_req && vec_ack |=> pc_vld && !vec_req && pc == $past(vec_data));

    assert_boot_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        vec_req && !vec_ack |=> !pc_vld && $stable(pc));

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        pc_vld && done && !br_req |=> pc == $past(pc) + 1'b1);

    assert_abs_R5: assert property (@(posedge clk) disable iff (rst)
        pc_vld && br_req && !br_rel |=> pc == $past(br_arg));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        pc_vld && !done && !br_req |=> $stable(pc));

endmodule

// File: tb/sim_pcseq_top.sv
module sim_pcseq_top;

    localparam int PC_W = 16;
    localparam int VA_W = 4;
    localparam int SLOT = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            done = 1'b0;
    logic            br_req = 1'b0;
    logic            br_rel = 1'b0;
    logic [PC_W-1:0] br_arg = '0;
    logic            vec_req;
    logic [VA_W-1:0] vec_addr;
    logic            vec_ack = 1'b0;
    logic [PC_W-1:0] vec_data = '0;
    logic [PC_W-1:0] pc;
    logic            pc_vld;

    int checks = 0;
    int errors = 0;
    logic [PC_W-1:0] exp_pc;

    always #5 clk = ~clk;

    pcseq_top u0 (
        .clk(clk), .rst(rst), .done(done), .br_req(br_req), .br_rel(br_rel),
        .br_arg(br_arg), .vec_req(vec_req), .vec_addr(vec_addr),
        .vec_ack(vec_ack), .vec_data(vec_data), .pc(pc), .pc_vld(pc_vld)
    );

    function automatic logic [PC_W-1:0] table_word(input logic [VA_W-1:0] a);
        return 16'hA000 + 16'(a) * 16'h0111;
    endfunction

    function automatic logic [PC_W-1:0] model(input logic [PC_W-1:0] p,
            input logic d, input logic b, input logic r, input logic [PC_W-1:0] a);
        if (b) return r ? p + {{8{a[7]}}, a[7:0]} : a;
        if (d) return p + 16'd1;
        return p;
    endfunction

    function automatic string tag_of(input logic d, input logic b, input logic r);
        if (b && d) return "R7";
        if (b) return r ? "R6" : "R5";
        if (d) return "R4";
        return "R8";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic d, input logic b, input logic r, input logic [PC_W-1:0] a);
        string t;
        t = tag_of(d, b, r);
        exp_pc = model(exp_pc, d, b, r, a);
        done = d; br_req = b; br_rel = r; br_arg = a;
        @(posedge clk);
        @(negedge clk);
        check(t, 32'(pc), 32'(exp_pc));
        check("R9", 32'(vec_req), 32'd0);
    endtask

    task automatic boot(input int stall);
        for (int i = 0; i < stall; i++) begin
            done = 1'b1; br_req = 1'b1; br_rel = i[0]; br_arg = 16'h1234;
            @(posedge clk);
            @(negedge clk);
            check("R3", {15'd0, pc_vld, pc}, 32'd0);
        end
        vec_ack = 1'b1;
        vec_data = table_word(vec_addr);
        @(posedge clk);
        @(negedge clk);
        vec_ack = 1'b0;
        done = 1'b0; br_req = 1'b0;
        check("R2", 32'(pc), 32'(table_word(VA_W'(SLOT))));
        check("R2", {pc_vld, vec_req}, 32'b10);
        exp_pc = pc;
    endtask

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", {pc_vld, vec_req, 12'd0, vec_addr}, {2'b01, 12'd0, 4'(SLOT)});
        check("R1", 32'(pc), 32'd0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", {pc_vld, vec_req}, 32'b01);
        boot(4);

        // directed corners
        step(1'b0, 1'b1, 1'b0, 16'hFFFF);         // R5 to all-ones
        step(1'b1, 1'b0, 1'b0, 16'h0000);         // R4 wrap to zero
        step(1'b0, 1'b1, 1'b0, 16'h0005);
        step(1'b0, 1'b1, 1'b1, 16'h0080);         // R6 -128 wraps below zero
        step(1'b1, 1'b1, 1'b1, 16'hAB01);         // R7 and R6 upper bits ignored
        step(1'b0, 1'b1, 1'b0, 16'hFFF0);
        step(1'b0, 1'b1, 1'b1, 16'h007F);         // R6 forward wrap
        step(1'b1, 1'b1, 1'b0, 16'h4321);         // R7 absolute beats step
        step(1'b0, 1'b0, 1'b1, 16'h5555);         // R8 hold

        for (int i = 0; i < 400; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            step(rv[0], rv[1] & rv[2], rv[3], rv[31:16]);
        end

        // R1 again on a mid-run reset, then reboot without stall
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", {pc_vld, vec_req, pc}, {2'b01, 16'd0});
        rst = 1'b0;
        boot(0);
        step(1'b1, 1'b0, 1'b0, 16'h0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule